// File: doc/BRIEF.md
# Audio Receive Sample FIFO

This block buffers received audio samples for one channel of a serial audio interface. The deserializer writes one sample per frame slot through a push strobe. The CPU removes samples through a pop request, and the sample appears on a registered read port one cycle later. The current fill level is exposed as an occupancy count.

Two conditions request service. A level flag rises when the buffer is close to full. It gates an interrupt through an enable input and drops by itself as the CPU drains entries. A sticky overrun bit records every attempt to write into a full buffer. That sample is thrown away and the stored samples are kept. The overrun bit always drives the interrupt and is cleared by a one-cycle pulse from the register interface.

Top module: `arx_sample_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `level` is 0 and `svc_req`, `ovr_sts` and `irq` are 0.
- R2: Samples come out in the order they were accepted. A pop request in cycle N places the oldest stored sample on `pop_data` after the clock edge that ends cycle N, and `pop_data` holds that sample until the next pop.
- R3: `level` counts accepted pushes minus accepted pops. It changes on the edge that accepts them and never exceeds the depth, which is 8 by default.
- R4: `svc_req` is 1 exactly when `level` is 6 or more, and 0 when `level` is 5 or less. It is updated on the same edge as `level` and needs no acknowledge.
- R5: After every edge, `irq` equals (`svc_req` AND the value `rx_irq_en` had before that edge) OR `ovr_sts`.
- R6: A pop request on an empty buffer makes `pop_data` read 0 and leaves `level` unchanged.
- R7: A push on a full buffer with no pop in the same cycle is discarded. `level` stays at the depth, and the stored samples and their order are unchanged.
- R8: `ovr_sts` is 1 after the edge that ends a cycle containing a push into a full buffer with no pop. Every such attempt sets it again.
- R9: `ovr_sts` stays set until an `ovr_clr` pulse clears it. If a discarded push and `ovr_clr` fall in the same cycle, the set wins.
- R10: A push and a pop in the same cycle on a full buffer are both accepted. `level` stays at the depth, the oldest sample is read out, and `ovr_sts` does not rise.
- R11: With `rx_irq_en` at 0, a high `svc_req` does not raise `irq`, but a set `ovr_sts` still does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Deserializer writes one sample this cycle |
| push_data | input | 16 | Sample to write |
| pop_req | input | 1 | CPU removes one sample this cycle |
| pop_data | output | 16 | Sample read out, valid from the cycle after `pop_req` |
| level | output | 4 | Number of stored samples |
| rx_irq_en | input | 1 | 1 lets `svc_req` drive `irq` |
| ovr_clr | input | 1 | One-cycle pulse that clears `ovr_sts` |
| svc_req | output | 1 | Buffer nearly full |
| ovr_sts | output | 1 | Sticky overrun status |
| irq | output | 1 | Interrupt request |

## Verification
Every result in this block is one register stage away from its stimulus. `level`, `svc_req`, `ovr_sts` and `irq` change on the edge that accepts a push, a pop or a clear. `pop_data` carries the sample on the edge that ends the cycle holding `pop_req`. The bench sets inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check reads the value due exactly one edge after its stimulus. The scoreboard predicts each popped sample from a software queue when the pop is issued. The monitor compares that prediction on the falling edge after the next rising edge.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int ARX_DATA_W  = 16;
  localparam int ARX_DEPTH   = 8;
  localparam int ARX_SET_LVL = 6;

  // decision taken by the pointer controller in one cycle
  typedef struct packed {
    logic push_ok;
    logic pop_ok;
    logic push_drop;
    logic pop_empty;
  } arx_xfer_t;
endpackage

// File: rtl/arx_store.sv
module arx_store #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NWORDS = 1 << AW;

  logic [DW-1:0] mem [NWORDS];
  logic [DW-1:0] rdata_q;

  // one process, read-first: same-address read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/arx_ptr_ctrl.sv
module arx_ptr_ctrl
  import arx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_vld,
  input  logic          pop_req,
  output arx_xfer_t     xfer,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    xfer.pop_ok    = pop_req && (cnt_q != '0);
    xfer.pop_empty = pop_req && (cnt_q == '0);
    xfer.push_ok   = push_vld && ((cnt_q != FULL_C) || xfer.pop_ok);
    xfer.push_drop = push_vld && !xfer.push_ok;
    count_nxt      = cnt_q + CW'(xfer.push_ok) - CW'(xfer.pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (xfer.push_ok) wr_q <= (wr_q == LAST_C) ? '0 : wr_q + 1'b1;
      if (xfer.pop_ok)  rd_q <= (rd_q == LAST_C) ? '0 : rd_q + 1'b1;
      cnt_q <= count_nxt;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign count  = cnt_q;
endmodule

// File: rtl/arx_status.sv
module arx_status #(
  parameter int CW      = 4,
  parameter int SET_LVL = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  input  logic          push_drop,
  input  logic          ovr_clr,
  input  logic          irq_en,
  output logic          svc_req,
  output logic          ovr_sts,
  output logic          irq
);
  localparam logic [CW-1:0] SET_C = CW'(SET_LVL);

  logic svc_d, ovr_d;
  logic svc_q, ovr_q, irq_q;

  always_comb begin
    svc_d = (count_nxt >= SET_C);
    // a fresh overrun beats a clear in the same cycle
    ovr_d = push_drop || (ovr_q && !ovr_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= 1'b0;
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      svc_q <= svc_d;
      ovr_q <= ovr_d;
      irq_q <= (svc_d && irq_en) || ovr_d;
    end
  end

  assign svc_req = svc_q;
  assign ovr_sts = ovr_q;
  assign irq     = irq_q;
endmodule

// File: rtl/arx_sample_fifo.sv
module arx_sample_fifo
  import arx_pkg::*;
#(
  parameter int DATA_W  = ARX_DATA_W,
  parameter int DEPTH   = ARX_DEPTH,
  parameter int SET_LVL = ARX_SET_LVL,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_vld,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     level,
  input  logic              rx_irq_en,
  input  logic              ovr_clr,
  output logic              svc_req,
  output logic              ovr_sts,
  output logic              irq
);
  arx_xfer_t         xfer;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_nxt;
  logic [DATA_W-1:0] store_q;
  logic              zero_q;

  arx_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .push_vld  (push_vld),
    .pop_req   (pop_req),
    .xfer      (xfer),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (level),
    .count_nxt (count_nxt)
  );

  arx_store #(.DW(DATA_W), .AW(AW)) u_store (
    .clk   (clk),
    .we    (xfer.push_ok),
    .waddr (wr_ptr),
    .wdata (push_data),
    .re    (xfer.pop_ok),
    .raddr (rd_ptr),
    .rdata (store_q)
  );

  arx_status #(.CW(CW), .SET_LVL(SET_LVL)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .count_nxt (count_nxt),
    .push_drop (xfer.push_drop),
    .ovr_clr   (ovr_clr),
    .irq_en    (rx_irq_en),
    .svc_req   (svc_req),
    .ovr_sts   (ovr_sts),
    .irq       (irq)
  );

  // empty-read marker: masks the block RAM output to zero
  always_ff @(posedge clk) begin
    if (rst)          zero_q <= 1'b1;
    else if (pop_req) zero_q <= xfer.pop_empty;
  end

  assign pop_data = zero_q ? '0 : store_q;
endmodule

// File: rtl/arx_sample_fifo_chk.sv
module arx_sample_fifo_chk #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int SET_LVL = 6,
  parameter int CW      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              push_vld,
  input logic              pop_req,
  input logic [DATA_W-1:0] pop_data,
  input logic [CW-1:0]     level,
  input logic              rx_irq_en,
  input logic              ovr_clr,
  input logic              svc_req,
  input logic              ovr_sts,
  input logic              irq
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] SET_C  = CW'(SET_LVL);

  p_level_max_r3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_C);

  p_svc_thresh_r4: assert property (@(posedge clk) disable iff (rst)
    svc_req == (level >= SET_C));

  p_irq_combine_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ((svc_req && $past(rx_irq_en)) || ovr_sts));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && pop_req && !push_vld) |=> (pop_data == '0 && level == '0));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_C && push_vld && !pop_req) |=> level == FULL_C);

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_C && push_vld && !pop_req) |=> ovr_sts);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_sts && !ovr_clr) |=> ovr_sts);

  p_full_both_r10: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_C && push_vld && pop_req && !ovr_sts) |=> (!ovr_sts && level == FULL_C));
endmodule

bind arx_sample_fifo arx_sample_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SET_LVL(SET_LVL), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .push_vld(push_vld), .pop_req(pop_req),
  .pop_data(pop_data), .level(level), .rx_irq_en(rx_irq_en),
  .ovr_clr(ovr_clr), .svc_req(svc_req), .ovr_sts(ovr_sts), .irq(irq)
);

// File: tb/arx_sample_fifo_bench.sv
`timescale 1ns/1ps
module arx_sample_fifo_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_vld = 1'b0;
  logic [15:0] push_data = '0;
  logic        pop_req = 1'b0;
  logic [15:0] pop_data;
  logic [3:0]  level;
  logic        rx_irq_en = 1'b1;
  logic        ovr_clr = 1'b0;
  logic        svc_req, ovr_sts, irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  mdl_q[$];
  int  exp_q[$];
  bit  emp_q[$];
  bit  mdl_ovr = 1'b0;
  logic pop_seen = 1'b0;

  always #5 clk = ~clk;

  arx_sample_fifo u_arx_sample_fifo (
    .clk(clk), .rst(rst), .push_vld(push_vld), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .level(level),
    .rx_irq_en(rx_irq_en), .ovr_clr(ovr_clr), .svc_req(svc_req),
    .ovr_sts(ovr_sts), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: pop issued at an edge, compared one half cycle later
  always @(posedge clk) pop_seen <= rst ? 1'b0 : pop_req;

  always @(negedge clk) begin
    if (pop_seen && exp_q.size() > 0) begin
      int  e;
      bit  em;
      e  = exp_q.pop_front();
      em = emp_q.pop_front();
      if (em) chk(pop_data == 16'(e), "R6 empty read", int'(pop_data), e);
      else    chk(pop_data == 16'(e), "R2 order",      int'(pop_data), e);
    end
  end

  // driver: one cycle of stimulus, entered and left on a falling edge
  task automatic step(input bit psh, input int d, input bit pop, input bit clr,
                      input string otag);
    int  sz;
    bit  pop_ok, drop;
    int  exp_irq;
    sz     = mdl_q.size();
    pop_ok = pop && sz > 0;
    drop   = psh && sz == DEPTH && !pop_ok;
    if (pop) begin
      exp_q.push_back(pop_ok ? mdl_q[0] : 0);
      emp_q.push_back(!pop_ok);
    end
    if (pop_ok) void'(mdl_q.pop_front());
    if (psh && !drop) mdl_q.push_back(d);
    if (drop) mdl_ovr = 1'b1;
    else if (clr) mdl_ovr = 1'b0;
    push_vld  = psh;
    push_data = 16'(d);
    pop_req   = pop;
    ovr_clr   = clr;
    @(posedge clk);
    @(negedge clk);
    push_vld = 1'b0;
    pop_req  = 1'b0;
    ovr_clr  = 1'b0;
    chk(int'(level) == mdl_q.size(), "R3 level", int'(level), mdl_q.size());
    chk(svc_req == (mdl_q.size() >= 6), "R4 svc_req", int'(svc_req),
        int'(mdl_q.size() >= 6));
    chk(ovr_sts == mdl_ovr, otag, int'(ovr_sts), int'(mdl_ovr));
    exp_irq = int'((mdl_q.size() >= 6 && rx_irq_en) || mdl_ovr);
    chk(int'(irq) == exp_irq, "R5/R11 irq", int'(irq), exp_irq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level == 0 && !svc_req && !ovr_sts && !irq, "R1 in reset",
        {level, svc_req, ovr_sts, irq}, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(level == 0 && !svc_req && !ovr_sts && !irq, "R1 after reset",
        {level, svc_req, ovr_sts, irq}, 0);

    // R6: read from empty, then push and pop together on empty
    step(0, 0, 1, 0, "R8 ovr");
    step(1, 16'h0aa1, 1, 0, "R8 ovr");
    step(0, 0, 1, 0, "R8 ovr");

    // fill: R4 threshold crossing at 6
    for (int i = 1; i <= 6; i++) step(1, 16'h100 + i, 0, 0, "R8 ovr");
    rx_irq_en = 1'b0;                  // R11: service request masked
    step(0, 0, 0, 0, "R8 ovr");
    rx_irq_en = 1'b1;
    step(0, 0, 0, 0, "R8 ovr");
    step(1, 16'h107, 0, 0, "R8 ovr");
    step(1, 16'h108, 0, 0, "R8 ovr");

    // R7/R8: push into full is dropped; set beats clear (R9)
    step(1, 16'hdead, 0, 0, "R8 ovr set");
    step(1, 16'hbeef, 0, 1, "R9 set over clear");
    step(0, 0, 0, 0, "R9 sticky");
    rx_irq_en = 1'b0;                  // R11: overrun still raises irq
    step(0, 0, 0, 0, "R9 sticky");
    rx_irq_en = 1'b1;
    step(0, 0, 0, 1, "R9 clear");

    // R10: push and pop together while full
    step(1, 16'h109, 1, 0, "R10 no overrun");

    // drain: R2 order, R7 contents intact, R4 falls at 5
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R8 ovr");
    step(0, 0, 1, 0, "R8 ovr");        // R6 empty again
    step(0, 0, 0, 0, "R8 ovr");

    chk(exp_q.size() == 0, "R2 all pops seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule